// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

A watchdog that software services through four word-addressed registers: a control word, a 16-bit timeout limit, a 16-bit window limit and the count register. Software never writes the count. It writes one of two key words to that address: one key opens the configuration registers for a single write, and the other restarts the count. Any other value written there is taken as a software fault and requests a reset at once.

The count advances on every clock, or once every 256 clocks when the prescaler is on, while the block is enabled and no gated low-power or debug state holds it. When the count reaches the timeout limit, the block either requests a reset directly or first raises an interrupt and requests the reset a programmed number of clocks later. In window mode, a restart key that arrives before the count reaches the window limit is an error and requests a reset. The reset request stays high until the block's own reset.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, rst_req and irq are 0, the control word reads 32'h0000_0002 (only update-allowed set), the timeout reads 16'hFFFF, the window reads 0 and the count reads 0.
- R2: Writing 32'h0818_1982 to address 3 unlocks configuration; control bit 30 reads 1 from the next cycle on.
- R3: A write to address 0, 1 or 2 while locked changes no configuration field and requests no reset.
- R4: One accepted write to address 0, 1 or 2 relocks the block; control bit 30 then reads 0.
- R5: If no configuration write follows, the unlock lapses after 128 clocks.
- R6: If update-allowed (control bit 1) was written 0, later unlock keys are ignored until reset.
- R7: Writing 32'h20CF_FC20 to address 3 sets the count to 0; with enable (bit 0) set and the interrupt reaction (bit 4) off, rst_req rises T+1 clocks after the restart, T being the timeout value.
- R8: With the prescaler (bit 3) on, the count advances once per 256 clocks, so rst_req rises 256*(T+1) clocks after a restart.
- R9: With window mode (bit 2) on, a restart key seen while the count is below the window value requests a reset; one seen at or above it restarts the count.
- R10: Any other value written to address 3 requests a reset on the next clock.
- R11: With bit 4 on, timeout sets irq (control bit 31) T+1 clocks after a restart, and rst_req follows D+1 clocks later, D being control bits 23:16; writing a 1 to bit 31 of the control word clears irq even while locked, leaving the other fields unchanged.
- R12: The count holds while dbg_mode, wait_mode or stop_mode is high unless the matching run bit (5, 6, 7) is set.
- R13: rst_req, once high, stays high until rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address: 0 control, 1 timeout, 2 window, 3 count/keys |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| dbg_mode | input | 1 | Chip is halted for debug |
| wait_mode | input | 1 | Chip is in wait state |
| stop_mode | input | 1 | Chip is in stop state |
| irq | output | 1 | Timeout interrupt flag |
| rst_req | output | 1 | Sticky reset request |

## Verification
Each register write is captured at one rising edge and its effect (lock status, stored value, reset request from a bad or early key) is visible on the following falling edge, where the bench samples it; reads are combinational and sampled a moment after the address settles. Timeout results are due a counted number of edges after the edge that captured the restart key: T+1 for a direct reset, 256*(T+1) with the prescaler, T+1 for the interrupt and T+D+2 for the delayed reset. The bench checks each of these one edge early (expecting no change) and exactly on time, and places window-mode restarts so the count seen is one below and exactly at the limit.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          CNT_W   = 16,
  parameter int          PRE_W   = 8,
  parameter int          DLY_W   = 8,
  parameter int          UNL_LIM = 128,
  parameter logic [31:0] UNL_KEY = 32'h0818_1982,
  parameter logic [31:0] REF_KEY = 32'h20CF_FC20,
  parameter logic [CNT_W-1:0] TO_RST  = '1,
  parameter logic [CNT_W-1:0] WIN_RST = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        dbg_mode,
  input  logic        wait_mode,
  input  logic        stop_mode,
  output logic        irq,
  output logic        rst_req
);
  localparam int UNL_W = $clog2(UNL_LIM + 1);

  logic             en_q, upd_q, win_q, pre_q, ie_q, rdbg_q, rwait_q, rstop_q;
  logic [1:0]       csel_q, tst_q;
  logic [DLY_W-1:0] dcfg_q, dly_q;
  logic [CNT_W-1:0] to_q, wv_q, cnt_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [UNL_W-1:0] unl_cnt;
  logic             unl_q, irqf_q, pend_q, rst_q;

  wire wr_ctl  = wr_en && addr == 2'd0;
  wire wr_to   = wr_en && addr == 2'd1;
  wire wr_win  = wr_en && addr == 2'd2;
  wire wr_cnt  = wr_en && addr == 2'd3;
  wire key_unl = wr_cnt && wdata == UNL_KEY;
  wire key_ref = wr_cnt && wdata == REF_KEY;
  wire key_bad = wr_cnt && !key_unl && !key_ref;
  wire cfg_wr  = unl_q && (wr_ctl || wr_to || wr_win);

  wire held    = (dbg_mode && !rdbg_q) || (wait_mode && !rwait_q) || (stop_mode && !rstop_q);
  wire run     = en_q && !pend_q && !rst_q && !held;
  wire tick    = run && (!pre_q || &pre_cnt);
  wire expire  = tick && cnt_q == to_q;
  wire early   = key_ref && en_q && win_q && cnt_q < wv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, win_q, pre_q, ie_q, rdbg_q, rwait_q, rstop_q} <= '0;
      upd_q  <= 1'b1;
      csel_q <= '0;
      tst_q  <= '0;
      dcfg_q <= '0;
      to_q   <= TO_RST;
      wv_q   <= WIN_RST;
    end else if (cfg_wr) begin
      if (wr_ctl) begin
        en_q    <= wdata[0];
        upd_q   <= wdata[1];
        win_q   <= wdata[2];
        pre_q   <= wdata[3];
        ie_q    <= wdata[4];
        rdbg_q  <= wdata[5];
        rwait_q <= wdata[6];
        rstop_q <= wdata[7];
        csel_q  <= wdata[9:8];
        tst_q   <= wdata[11:10];
        dcfg_q  <= wdata[16 +: DLY_W];
      end
      if (wr_to)  to_q <= wdata[CNT_W-1:0];
      if (wr_win) wv_q <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q   <= 1'b0;
      unl_cnt <= '0;
    end else if (key_unl && upd_q) begin
      unl_q   <= 1'b1;
      unl_cnt <= '0;
    end else if (cfg_wr) begin
      unl_q   <= 1'b0;
    end else if (unl_q) begin
      if (unl_cnt == UNL_W'(UNL_LIM - 1)) unl_q <= 1'b0;
      else unl_cnt <= unl_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pre_cnt <= '0;
    end else if (key_ref && !early) begin
      cnt_q   <= '0;
      pre_cnt <= '0;
    end else if (run) begin
      if (pre_q) pre_cnt <= pre_cnt + 1'b1;
      if (tick && !expire) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqf_q <= 1'b0;
      pend_q <= 1'b0;
      dly_q  <= '0;
      rst_q  <= 1'b0;
    end else begin
      if (expire && ie_q) begin
        irqf_q <= 1'b1;
        pend_q <= 1'b1;
        dly_q  <= dcfg_q;
      end else begin
        if (wr_ctl && wdata[31]) irqf_q <= 1'b0;
        if (pend_q && dly_q != '0) dly_q <= dly_q - 1'b1;
      end
      if (key_bad || early || (expire && !ie_q) || (pend_q && dly_q == '0))
        rst_q <= 1'b1;
    end
  end

  wire [31:0] ctl_rd = {irqf_q, unl_q, 6'b0, 8'(dcfg_q), 4'b0, tst_q, csel_q,
                        rstop_q, rwait_q, rdbg_q, ie_q, pre_q, win_q, upd_q, en_q};

  always_comb begin
    case (addr)
      2'd0:    rdata = ctl_rd;
      2'd1:    rdata = 32'(to_q);
      2'd2:    rdata = 32'(wv_q);
      default: rdata = 32'(cnt_q);
    endcase
  end

  assign irq     = irqf_q;
  assign rst_req = rst_q;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int          CNT_W   = 16,
  parameter int          UNL_LIM = 128,
  parameter logic [31:0] UNL_KEY = 32'h0818_1982,
  parameter logic [31:0] REF_KEY = 32'h20CF_FC20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [31:0]      wdata,
  input logic             rst_req,
  input logic             unl,
  input logic [CNT_W-1:0] toval
);
  localparam int HW = $clog2(UNL_LIM + 2);
  logic [HW-1:0] open_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_cnt <= '0;
    else if (wr_en && addr == 2'd3 && wdata == UNL_KEY) open_cnt <= '0;
    else if (unl) open_cnt <= open_cnt + 1'b1;
    else open_cnt <= '0;
  end

  a_r10_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata != UNL_KEY && wdata != REF_KEY) |=> rst_req);

  a_r13_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  a_r3_locked_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !unl) |=> $stable(toval));

  a_r4_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (unl && wr_en && addr != 2'd3) |=> !unl);

  a_r5_unlock_lapse: assert property (@(posedge clk) disable iff (!rst_n)
    open_cnt <= HW'(UNL_LIM));
endmodule

bind keyed_wdt keyed_wdt_chk #(
  .CNT_W(CNT_W), .UNL_LIM(UNL_LIM), .UNL_KEY(UNL_KEY), .REF_KEY(REF_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rst_req(rst_req), .unl(unl_q), .toval(to_q)
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] UNL = 32'h0818_1982;
  localparam logic [31:0] REF = 32'h20CF_FC20;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic dbg_mode = 1'b0, wait_mode = 1'b0, stop_mode = 1'b0;
  logic irq, rst_req;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dbg_mode(dbg_mode), .wait_mode(wait_mode),
    .stop_mode(stop_mode), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    dbg_mode = 1'b0; wait_mode = 1'b0; stop_mode = 1'b0;
    cycles(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    wr(2'd3, UNL);
    wr(a, d);
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    do_reset();
    chk("R1 rst_req", 32'(rst_req), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0000_0002);
    rd(2'd1, v); chk("R1 timeout", v, 32'h0000_FFFF);
    rd(2'd2, v); chk("R1 window", v, 0);
    rd(2'd3, v); chk("R1 count", v, 0);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    do_reset();
    wr(2'd1, 32'h55);
    rd(2'd1, v); chk("R3 locked timeout write", v, 32'h0000_FFFF);
    chk("R3 no reset", 32'(rst_req), 0);
    wr(2'd3, UNL);
    rd(2'd0, v); chk("R2 unlocked bit", 32'(v[30]), 1);
    wr(2'd1, 32'h55);
    rd(2'd1, v); chk("R4 accepted write", v, 32'h55);
    rd(2'd0, v); chk("R4 relocked", 32'(v[30]), 0);
    wr(2'd2, 32'h33);
    rd(2'd2, v); chk("R4 second write ignored", v, 0);
    wr(2'd3, UNL);
    cycles(100);
    rd(2'd0, v); chk("R5 still open", 32'(v[30]), 1);
    cycles(40);
    rd(2'd0, v); chk("R5 lapsed", 32'(v[30]), 0);
    wr(2'd1, 32'h77);
    rd(2'd1, v); chk("R5 write after lapse", v, 32'h55);
  endtask

  task automatic t_no_update;
    logic [31:0] v;
    do_reset();
    cfg(2'd0, 32'h0);
    wr(2'd3, UNL);
    rd(2'd0, v); chk("R6 key ignored", 32'(v[30]), 0);
    wr(2'd1, 32'h99);
    rd(2'd1, v); chk("R6 timeout unchanged", v, 32'h0000_FFFF);
    chk("R6 no reset", 32'(rst_req), 0);
    do_reset();
    wr(2'd3, UNL);
    rd(2'd0, v); chk("R6 unlock after reset", 32'(v[30]), 1);
  endtask

  task automatic t_timeout;
    logic [31:0] v;
    do_reset();
    cfg(2'd1, 32'd20);
    cfg(2'd0, 32'h3);
    wr(2'd3, REF);
    rd(2'd3, v); chk("R7 count restarted", v, 0);
    cycles(20);
    chk("R7 before timeout", 32'(rst_req), 0);
    cycles(1);
    chk("R7 timeout reset", 32'(rst_req), 1);
    cycles(10);
    chk("R13 sticky", 32'(rst_req), 1);
  endtask

  task automatic t_prescale;
    do_reset();
    cfg(2'd1, 32'd2);
    cfg(2'd0, 32'hB);
    wr(2'd3, REF);
    cycles(767);
    chk("R8 before timeout", 32'(rst_req), 0);
    cycles(1);
    chk("R8 timeout reset", 32'(rst_req), 1);
  endtask

  task automatic t_window;
    logic [31:0] v;
    do_reset();
    cfg(2'd1, 32'd100);
    cfg(2'd2, 32'd10);
    cfg(2'd0, 32'h7);
    cycles(15);
    wr(2'd3, REF);
    chk("R9 late restart ok", 32'(rst_req), 0);
    cycles(9);
    wr(2'd3, REF);
    chk("R9 restart at limit", 32'(rst_req), 0);
    rd(2'd3, v); chk("R9 count zeroed", v, 0);
    cycles(8);
    wr(2'd3, REF);
    chk("R9 early restart", 32'(rst_req), 1);
  endtask

  task automatic t_bad_key;
    do_reset();
    wr(2'd3, 32'h1234_5678);
    chk("R10 bad key", 32'(rst_req), 1);
    cycles(5);
    chk("R13 held", 32'(rst_req), 1);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    do_reset();
    cfg(2'd1, 32'd10);
    cfg(2'd0, 32'h0005_0013);
    wr(2'd3, REF);
    cycles(10);
    chk("R11 irq not yet", 32'(irq), 0);
    cycles(1);
    chk("R11 irq set", 32'(irq), 1);
    chk("R11 reset delayed", 32'(rst_req), 0);
    cycles(5);
    chk("R11 reset still delayed", 32'(rst_req), 0);
    cycles(1);
    chk("R11 delayed reset", 32'(rst_req), 1);
    wr(2'd0, 32'h8000_0000);
    chk("R11 irq cleared", 32'(irq), 0);
    rd(2'd0, v); chk("R11 fields kept", v, 32'h0005_0013);
  endtask

  task automatic t_gating;
    logic [31:0] a, v;
    do_reset();
    cfg(2'd1, 32'd1000);
    cfg(2'd0, 32'h3);
    @(negedge clk) dbg_mode = 1'b1;
    rd(2'd3, a);
    cycles(50);
    rd(2'd3, v); chk("R12 frozen in debug", v, a);
    @(negedge clk) dbg_mode = 1'b0; wait_mode = 1'b1;
    rd(2'd3, a);
    cycles(20);
    rd(2'd3, v); chk("R12 frozen in wait", v, a);
    @(negedge clk) wait_mode = 1'b0;
    rd(2'd3, a);
    cycles(10);
    rd(2'd3, v); chk("R12 runs normally", v, a + 10);
    cfg(2'd0, 32'h83);
    @(negedge clk) stop_mode = 1'b1;
    rd(2'd3, a);
    cycles(10);
    rd(2'd3, v); chk("R12 runs in stop when allowed", v, a + 10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_lock();
    t_no_update();
    t_timeout();
    t_prescale();
    t_window();
    t_bad_key();
    t_irq();
    t_gating();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule